// File: doc/BRIEF.md
# Multi-Mode Load Address Generator

This block turns one decoded load request into the byte address of the operand in memory. A request carries a mode, an access size, a base register value, an index register value and an immediate. The block applies one of eight addressing modes and returns the final address with a single-cycle valid strobe. For the auto-modify modes it also returns the stepped base value with a write enable, so that the register file can update the base register.

Seven of the modes are computed directly from the request, and their address appears one cycle after the request is accepted. The pointer mode first issues a single read on a simple request/response memory port at the base address. The word that comes back becomes the final address. While a request is in progress the block drops `reqReady` and ignores any new request.

All arithmetic is 32-bit and wraps silently.

Top module: `eaddr_gen`

## Requirements
- R1: Mode code 0 (absolute) returns the immediate as the address.
- R2: Mode code 1 (register) returns the base value as the address.
- R3: Mode code 2 (displaced) returns base plus immediate.
- R4: Mode code 3 (indexed) returns base plus index, and mode code 4 (scaled) returns base plus index times four.
- R5: Mode code 5 (pointer) raises `memReqValid` for exactly one cycle, in the cycle after acceptance, with `memReqAddr` equal to the base value at acceptance. The cycle after the edge that samples `memRspValid` high carries the address strobe, and the address equals the `memRspData` sampled at that edge.
- R6: Mode code 6 (post-increment) returns the base as the address, and the write-back value is base plus step.
- R7: Mode code 7 (pre-decrement) returns base minus step as the address, and the write-back value is that same value.
- R8: `reqSize` encodes the step: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes.
- R9: `wbEn` is high only in the strobe cycle of modes 6 and 7, and it is never high outside a strobe cycle.
- R10: For every mode other than 5, `addrValid` is high in the cycle after acceptance. `addrValid` is always a single-cycle pulse.
- R11: All sums and differences wrap modulo 2^32 with no other effect.
- R12: `reqReady` is high only when the block is idle. A request presented while `reqReady` is low is ignored, and request fields are captured at acceptance.
- R13: After reset `reqReady` is high, and `addrValid`, `wbEn` and `memReqValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reqValid | input | 1 | request present |
| reqReady | output | 1 | block idle, request accepted this cycle |
| reqMode | input | 3 | addressing mode code |
| reqSize | input | 2 | access size code |
| baseVal | input | 32 | base register contents |
| indexVal | input | 32 | index register contents |
| immVal | input | 32 | immediate / displacement |
| memReqValid | output | 1 | pointer read request |
| memReqAddr | output | 32 | pointer read address |
| memRspValid | input | 1 | pointer read response present |
| memRspData | input | 32 | pointer word returned |
| addrValid | output | 1 | final address strobe |
| addrOut | output | 32 | final address |
| wbEn | output | 1 | base write-back enable |
| wbData | output | 32 | stepped base value |

## Verification
The bench aims at wrap-around at both ends of the address space. A design that saturates or traps there returns a wrong address or write-back value. It drives pointer responses after delays of varying length, and while waiting it changes the request inputs and holds `reqValid` high. A design that reads the live inputs instead of the captured ones, or accepts a second request, shows a wrong address or an extra strobe. It walks every size code through both auto-modify modes. This catches a swapped pre- and post-step, a wrong step width, or a write enable that leaks into other modes.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;
  typedef enum logic [2:0] {
    MODE_ABS    = 3'd0,
    MODE_REG    = 3'd1,
    MODE_DISP   = 3'd2,
    MODE_IDX    = 3'd3,
    MODE_SCALED = 3'd4,
    MODE_PTR    = 3'd5,
    MODE_POSTINC = 3'd6,
    MODE_PREDEC = 3'd7
  } eaMode_e;

  typedef struct packed {
    logic captureReq;
    logic captureRsp;
  } eaStrobe_t;
endpackage

// File: rtl/eaddr_dp.sv
module eaddr_dp
  import eaddr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SCALE_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eaStrobe_t         strobes,
  input  logic [2:0]        reqMode,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] immVal,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] wbData
);
  logic [ADDR_W-1:0] addrReg, wbReg, ptrReg;
  logic [ADDR_W-1:0] stepBytes, scaledIdx, eaComb, wbComb;

  always_comb begin
    unique case (reqSize)
      2'd0:    stepBytes = ADDR_W'(1);
      2'd1:    stepBytes = ADDR_W'(2);
      default: stepBytes = ADDR_W'(4);
    endcase
  end

  generate
    if (SCALE_SHIFT == 0) begin : g_noScale
      assign scaledIdx = indexVal;
    end else begin : g_scale
      assign scaledIdx = {indexVal[ADDR_W-1-SCALE_SHIFT:0], {SCALE_SHIFT{1'b0}}};
    end
  endgenerate

  always_comb begin
    wbComb = baseVal;
    unique case (eaMode_e'(reqMode))
      MODE_ABS:     eaComb = immVal;
      MODE_REG:     eaComb = baseVal;
      MODE_DISP:    eaComb = baseVal + immVal;
      MODE_IDX:     eaComb = baseVal + indexVal;
      MODE_SCALED:  eaComb = baseVal + scaledIdx;
      MODE_PTR:     eaComb = baseVal;
      MODE_POSTINC: begin
        eaComb = baseVal;
        wbComb = baseVal + stepBytes;
      end
      default: begin
        eaComb = baseVal - stepBytes;
        wbComb = baseVal - stepBytes;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrReg <= '0;
      wbReg   <= '0;
      ptrReg  <= '0;
    end else if (strobes.captureReq) begin
      addrReg <= eaComb;
      wbReg   <= wbComb;
      ptrReg  <= baseVal;
    end else if (strobes.captureRsp) begin
      addrReg <= memRspData;
    end
  end

  assign memReqAddr = ptrReg;
  assign addrOut    = addrReg;
  assign wbData     = wbReg;

  AST_CAPTURE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.captureReq && strobes.captureRsp)); // R12
endmodule

// File: rtl/eaddr_ctrl.sv
module eaddr_ctrl
  import eaddr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [2:0] reqMode,
  input  logic       memRspValid,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       addrValid,
  output logic       wbEn,
  output eaStrobe_t  strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_PTR_REQ, ST_PTR_WAIT, ST_DONE} state_e;
  state_e state;
  logic   autoFlag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      autoFlag <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state    <= (eaMode_e'(reqMode) == MODE_PTR) ? ST_PTR_REQ : ST_DONE;
          autoFlag <= (eaMode_e'(reqMode) == MODE_POSTINC) ||
                      (eaMode_e'(reqMode) == MODE_PREDEC);
        end
        ST_PTR_REQ:  state <= ST_PTR_WAIT;
        ST_PTR_WAIT: if (memRspValid) state <= ST_DONE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.captureReq = (state == ST_IDLE) && reqValid;
    strobes.captureRsp = (state == ST_PTR_WAIT) && memRspValid;
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_PTR_REQ);
  assign addrValid   = (state == ST_DONE);
  assign wbEn        = (state == ST_DONE) && autoFlag;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid |=> !addrValid); // R10
  AST_DIRECT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && reqMode != 3'd5) |=> addrValid); // R10
  AST_WB_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wbEn |-> addrValid); // R9
  AST_PTR_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |=> !memReqValid); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid || memReqValid) |-> !reqReady); // R12
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
  import eaddr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SCALE_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqMode,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [ADDR_W-1:0] immVal,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbData
);
  eaStrobe_t strobes;

  eaddr_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqMode(reqMode),
    .memRspValid(memRspValid), .reqReady(reqReady), .memReqValid(memReqValid),
    .addrValid(addrValid), .wbEn(wbEn), .strobes(strobes)
  );

  eaddr_dp #(.ADDR_W(ADDR_W), .SCALE_SHIFT(SCALE_SHIFT)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .reqMode(reqMode),
    .reqSize(reqSize), .baseVal(baseVal), .indexVal(indexVal), .immVal(immVal),
    .memRspData(memRspData), .memReqAddr(memReqAddr), .addrOut(addrOut),
    .wbData(wbData)
  );

  AST_PTR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && reqMode == 3'd5) |=> (memReqValid && memReqAddr == $past(baseVal))); // R5
  AST_WB_AUTO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && reqMode < 3'd6) |=> !wbEn); // R9
endmodule

// File: tb/eaddr_gen_tb_top.sv
module eaddr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [2:0] reqMode = '0;
  logic [1:0] reqSize = '0;
  logic [31:0] baseVal = '0, indexVal = '0, immVal = '0;
  logic memReqValid;
  logic [31:0] memReqAddr;
  logic memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic addrValid;
  logic [31:0] addrOut;
  logic wbEn;
  logic [31:0] wbData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eaddr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqSize(reqSize), .baseVal(baseVal), .indexVal(indexVal),
    .immVal(immVal), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .addrValid(addrValid),
    .addrOut(addrOut), .wbEn(wbEn), .wbData(wbData)
  );

  function automatic logic [31:0] stepOf(input logic [1:0] sz); // R8
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] expAddr(input logic [2:0] m, input logic [1:0] sz,
      input logic [31:0] b, input logic [31:0] x, input logic [31:0] im);
    case (m)
      3'd0: return im;            // R1
      3'd1: return b;             // R2
      3'd2: return b + im;        // R3
      3'd3: return b + x;         // R4
      3'd4: return b + x * 4;     // R4
      3'd6: return b;             // R6
      3'd7: return b - stepOf(sz); // R7
      default: return b;
    endcase
  endfunction

  function automatic logic [31:0] expWb(input logic [2:0] m, input logic [1:0] sz,
      input logic [31:0] b);
    return (m == 3'd6) ? b + stepOf(sz) : b - stepOf(sz);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
      input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic runReq(input logic [2:0] m, input logic [1:0] sz, input logic [31:0] b,
      input logic [31:0] x, input logic [31:0] im, input int rspDelay,
      input logic [31:0] ptrWord);
    logic [31:0] ea;
    ea = (m == 3'd5) ? ptrWord : expAddr(m, sz, b, x, im);
    @(negedge clk);
    chk(reqReady, "R12 ready when idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqMode = m; reqSize = sz; baseVal = b; indexVal = x; immVal = im;
    @(negedge clk);
    // change the inputs after acceptance; the block must hold its captured copy
    baseVal = ~b; indexVal = ~x; immVal = ~im; reqMode = 3'd0;
    if (m == 3'd5) begin
      chk(memReqValid && memReqAddr == b, "R5 pointer request", memReqAddr, b);
      chk(!addrValid, "R5 no early strobe", 32'(addrValid), 32'd0);
      for (int k = 0; k < rspDelay; k++) begin
        @(negedge clk);
        chk(!memReqValid && !addrValid && !reqReady, "R12 busy waiting",
            {29'd0, memReqValid, addrValid, reqReady}, 32'd0);
      end
      @(negedge clk);
      reqValid = 1'b0;
      memRspValid = 1'b1; memRspData = ptrWord;
      @(negedge clk);
      memRspValid = 1'b0; memRspData = ~ptrWord;
    end else begin
      reqValid = 1'b0;
    end
    chk(addrValid, "R10 strobe timing", 32'(addrValid), 32'd1);
    chk(addrOut == ea, $sformatf("R1-mode%0d address", m), addrOut, ea);
    chk(wbEn == (m >= 3'd6), "R9 write enable", 32'(wbEn), 32'(m >= 3'd6));
    if (m >= 3'd6)
      chk(wbData == expWb(m, sz, b), "R6 R7 write-back value", wbData, expWb(m, sz, b));
    @(negedge clk);
    chk(!addrValid && !wbEn && reqReady, "R10 single pulse",
        {30'd0, addrValid, wbEn}, 32'd0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seedv;
    seedv = 32'd20240611;
    void'($urandom(seedv));
    repeat (3) @(negedge clk);
    chk(reqReady && !addrValid && !wbEn && !memReqValid, "R13 reset state",
        {28'd0, reqReady, addrValid, wbEn, memReqValid}, 32'h8);
    rst_n = 1'b1;
    // R1 R2 R3 R4 directed
    runReq(3'd0, 2'd2, 32'h1111_0000, 32'h5, 32'hCAFE_0010, 0, 0);
    runReq(3'd1, 2'd2, 32'h2000_0040, 32'h5, 32'h7, 0, 0);
    runReq(3'd2, 2'd0, 32'h0000_1000, 32'h0, 32'hFFFF_FFF0, 0, 0);
    runReq(3'd3, 2'd1, 32'h0000_1000, 32'h0000_0300, 32'h0, 0, 0);
    runReq(3'd4, 2'd1, 32'h0000_1000, 32'h0000_0300, 32'h0, 0, 0);
    // R11 wrap cases
    runReq(3'd2, 2'd2, 32'hFFFF_FFF0, 32'h0, 32'h0000_0020, 0, 0);
    runReq(3'd4, 2'd2, 32'h8000_0000, 32'h6000_0000, 32'h0, 0, 0);
    runReq(3'd6, 2'd2, 32'hFFFF_FFFE, 32'h0, 32'h0, 0, 0);
    runReq(3'd7, 2'd1, 32'h0000_0001, 32'h0, 32'h0, 0, 0);
    // R6 R7 R8 every size code
    for (int s = 0; s < 4; s++) begin
      runReq(3'd6, 2'(s), 32'h0000_4000, 32'h0, 32'h0, 0, 0);
      runReq(3'd7, 2'(s), 32'h0000_4000, 32'h0, 32'h0, 0, 0);
    end
    // R5 pointer mode, various latencies, request held high while busy (R12)
    runReq(3'd5, 2'd2, 32'h0000_8000, 32'h1, 32'h2, 0, 32'hDEAD_BEE0);
    runReq(3'd5, 2'd2, 32'hFFFF_FFFC, 32'h1, 32'h2, 5, 32'h0000_0044);
    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      runReq(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), $urandom, $urandom,
             $urandom, $urandom_range(0, 4), $urandom);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule